// File: doc/BRIEF.md
# Load Writeback Scoreboard Controller

This block sits beside the register file of a small in-order core. Ordinary instructions go through fetch, decode, execute and writeback. A load adds a memory stage of variable length between execute and writeback. The controller records the one load that may be in flight: its destination register, and whether a younger instruction has already overwritten that register.

Each cycle it makes three decisions. First, it stalls decode when the instruction there reads the load's target, or is itself a load. Second, it lets younger independent results reach the register file while the load is still waiting, so they complete out of order. Third, it discards the load's writeback when a younger instruction has written the same register.

The memory stage ends only when a ready handshake arrives, so the number of cycles a load waits is not fixed. The register file has a single write port. When returning load data and an execute-stage result want that port in the same cycle, the load goes first and the execute-stage instruction is held for one cycle.

Top module: `ldsb_top`

## Requirements
- R1: A synchronous active-high reset clears the pending load. In the cycle after reset, `rf_we`, `stall` and `ex_hold` are all 0, and a register that was the target of a load before the reset no longer stalls decode.
- R2: With no load pending, an execute-stage write request is applied one cycle later: `rf_we`=1, `rf_waddr` equal to the requested register, and `rf_wsel`=0 (0 selects the execute result, 1 selects load data).
- R3: When `mem_ready` is high while a load is pending and not cancelled, and no execute write to another register competes, the next cycle shows `rf_we`=1, `rf_wsel`=1 and `rf_waddr` equal to the load destination. The pending state clears at that same edge.
- R4: While a load is pending, an execute-stage write to a different register is applied one cycle later without waiting for the load. A decoded instruction whose two sources both differ from the load destination is not stalled.
- R5: While a non-cancelled load is pending, `stall` is 1 whenever `dec_valid` is 1 and either source field matches the load destination. Source A is in `dec_src[3:0]` and source B is in `dec_src[7:4]`. The stall lasts until the cycle after `mem_ready`.
- R6: At most one load is outstanding. A decoded load (`dec_is_load`=1) stalls for as long as any load is pending, whether or not that load has been cancelled.
- R7: An execute-stage write to the pending load's destination register cancels the load. That write goes ahead without a stall. Readers of the register are no longer stalled. The later `mem_ready` clears the pending state but causes no register write.
- R8: If `mem_ready` for a non-cancelled load coincides with an execute write to a different register, `ex_hold` is 1 in that cycle. The load data is written in the next cycle. The held instruction, presented again, is written one cycle after that.
- R9: If `mem_ready` coincides with an execute write to the load's own destination, `ex_hold` stays 0. Only the execute result is written, and the load data is dropped.
- R10: A load stays pending for any number of cycles until `mem_ready` arrives. A `mem_ready` while no load is pending causes no write.
- R11: When `dec_valid` is 0, for example during a fetch bubble, `stall` is 0 and the decode inputs change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_is_load | input | 1 | Decoded instruction is a load |
| dec_src | input | 8 | Source register fields: A in [3:0], B in [7:4] |
| ex_wr_req | input | 1 | Execute-stage instruction requests a register write |
| ex_wr_reg | input | 4 | Destination of the execute-stage write |
| ld_issue | input | 1 | A load leaves execute and enters the memory stage |
| ld_dst | input | 4 | Destination register of the issuing load |
| mem_ready | input | 1 | Memory returns data for the pending load |
| stall | output | 1 | Hold the decode stage this cycle |
| ex_hold | output | 1 | Hold the execute-stage write for one cycle (port busy) |
| rf_we | output | 1 | Register file write enable (registered) |
| rf_waddr | output | 4 | Register file write address (registered) |
| rf_wsel | output | 1 | Write data select: 0 execute result, 1 load data |

## Verification
Two pairs of functions can fall in the same cycle. In the first, load data returns while an execute result also wants the single write port. In the second, that returning load is met by a younger write to its own destination. The bench raises `mem_ready` together with `ex_wr_req`, once to a different register and once to the same one. It then judges the result by the `ex_hold` level in that cycle and by the order and select values of the writes that the scoreboard queue pops. A dropped load shows up as a write the queue does not expect.

// File: rtl/ldsb_pkg.sv
package ldsb_pkg;

  // Source of the data driven into the register file write port
  typedef enum logic {
    WSEL_EXEC = 1'b0,
    WSEL_LOAD = 1'b1
  } wsel_e;

endpackage

// File: rtl/ldsb_tracker.sv
// Holds the single outstanding load: valid flag, destination, dropped flag.
module ldsb_tracker #(
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_issue,
  input  logic [REG_W-1:0] ld_dst,
  input  logic             mem_ready,
  input  logic             cancel_now,
  output logic             pend_valid,
  output logic             pend_dropped,
  output logic [REG_W-1:0] pend_dst,
  output logic             load_ret
);

  assign load_ret = pend_valid & mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid   <= 1'b0;
      pend_dropped <= 1'b0;
      pend_dst     <= '0;
    end else if (ld_issue) begin
      pend_valid   <= 1'b1;
      pend_dropped <= 1'b0;
      pend_dst     <= ld_dst;
    end else if (load_ret) begin
      // Response is consumed whether or not the data will be written
      pend_valid   <= 1'b0;
      pend_dropped <= 1'b0;
    end else if (cancel_now) begin
      pend_dropped <= 1'b1;
    end
  end

endmodule

// File: rtl/ldsb_hazard.sv
// Decode-stage interlock: read-after-load and one-load-in-flight.
module ldsb_hazard #(
  parameter int REG_W   = 4,
  parameter int NUM_SRC = 2
) (
  input  logic                     dec_valid,
  input  logic                     dec_is_load,
  input  logic [NUM_SRC*REG_W-1:0] dec_src,
  input  logic                     pend_valid,
  input  logic                     pend_dropped,
  input  logic [REG_W-1:0]         pend_dst,
  output logic                     stall
);

  logic [NUM_SRC-1:0] src_hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign src_hit[i] = (dec_src[i*REG_W +: REG_W] == pend_dst);
  end

  logic raw_wait;
  assign raw_wait = (|src_hit) & ~pend_dropped;

  assign stall = dec_valid & pend_valid & (dec_is_load | raw_wait);

endmodule

// File: rtl/ldsb_wport.sv
// Single write port arbitration, cancel detection and registered write command.
module ldsb_wport
  import ldsb_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ex_wr_req,
  input  logic [REG_W-1:0] ex_wr_reg,
  input  logic             load_ret,
  input  logic             pend_valid,
  input  logic             pend_dropped,
  input  logic [REG_W-1:0] pend_dst,
  output logic             cancel_now,
  output logic             ex_hold,
  output logic             rf_we,
  output logic [REG_W-1:0] rf_waddr,
  output logic             rf_wsel
);

  logic  same_dst;
  logic  load_wr;
  wsel_e sel_q;

  assign same_dst   = ex_wr_req & pend_valid & (ex_wr_reg == pend_dst);
  assign cancel_now = same_dst;
  assign load_wr    = load_ret & ~pend_dropped & ~same_dst;
  assign ex_hold    = load_wr & ex_wr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      sel_q    <= WSEL_EXEC;
    end else if (load_wr) begin
      rf_we    <= 1'b1;
      rf_waddr <= pend_dst;
      sel_q    <= WSEL_LOAD;
    end else if (ex_wr_req) begin
      rf_we    <= 1'b1;
      rf_waddr <= ex_wr_reg;
      sel_q    <= WSEL_EXEC;
    end else begin
      rf_we    <= 1'b0;
    end
  end

  assign rf_wsel = sel_q;

endmodule

// File: rtl/ldsb_top.sv
module ldsb_top #(
  parameter int REG_W   = 4,
  parameter int NUM_SRC = 2,
  localparam int SRC_W  = NUM_SRC * REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic             dec_is_load,
  input  logic [SRC_W-1:0] dec_src,
  input  logic             ex_wr_req,
  input  logic [REG_W-1:0] ex_wr_reg,
  input  logic             ld_issue,
  input  logic [REG_W-1:0] ld_dst,
  input  logic             mem_ready,
  output logic             stall,
  output logic             ex_hold,
  output logic             rf_we,
  output logic [REG_W-1:0] rf_waddr,
  output logic             rf_wsel
);

  logic             pend_valid;
  logic             pend_dropped;
  logic [REG_W-1:0] pend_dst;
  logic             load_ret;
  logic             cancel_now;

  ldsb_tracker #(.REG_W(REG_W)) u_trk (
    .clk          (clk),
    .rst          (rst),
    .ld_issue     (ld_issue),
    .ld_dst       (ld_dst),
    .mem_ready    (mem_ready),
    .cancel_now   (cancel_now),
    .pend_valid   (pend_valid),
    .pend_dropped (pend_dropped),
    .pend_dst     (pend_dst),
    .load_ret     (load_ret)
  );

  ldsb_hazard #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_haz (
    .dec_valid    (dec_valid),
    .dec_is_load  (dec_is_load),
    .dec_src      (dec_src),
    .pend_valid   (pend_valid),
    .pend_dropped (pend_dropped),
    .pend_dst     (pend_dst),
    .stall        (stall)
  );

  ldsb_wport #(.REG_W(REG_W)) u_wp (
    .clk          (clk),
    .rst          (rst),
    .ex_wr_req    (ex_wr_req),
    .ex_wr_reg    (ex_wr_reg),
    .load_ret     (load_ret),
    .pend_valid   (pend_valid),
    .pend_dropped (pend_dropped),
    .pend_dst     (pend_dst),
    .cancel_now   (cancel_now),
    .ex_hold      (ex_hold),
    .rf_we        (rf_we),
    .rf_waddr     (rf_waddr),
    .rf_wsel      (rf_wsel)
  );

endmodule

// File: rtl/ldsb_checker.sv
module ldsb_checker #(
  parameter int REG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             dec_valid,
  input logic             dec_is_load,
  input logic             ex_wr_req,
  input logic [REG_W-1:0] ex_wr_reg,
  input logic             ld_issue,
  input logic             mem_ready,
  input logic             stall,
  input logic             ex_hold,
  input logic             rf_we,
  input logic [REG_W-1:0] rf_waddr,
  input logic             rf_wsel,
  input logic             pend_valid,
  input logic             pend_dropped,
  input logic [REG_W-1:0] pend_dst
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!rf_we && !pend_valid));

  // R2
  exec_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend_valid && ex_wr_req && !ld_issue) |=>
      (rf_we && !rf_wsel && rf_waddr == $past(ex_wr_reg)));

  // R3
  load_write_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && mem_ready && !pend_dropped && !ex_wr_req) |=>
      (rf_we && rf_wsel && !pend_valid));

  // R6
  second_load_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && dec_valid && dec_is_load) |-> stall);

  // R8
  hold_order_chk: assert property (@(posedge clk) disable iff (rst)
    ex_hold |=> (rf_we && rf_wsel));

  // R9
  same_dst_nohold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && mem_ready && ex_wr_req && ex_wr_reg == pend_dst) |-> !ex_hold);

  // R9
  same_dst_exec_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && mem_ready && ex_wr_req && ex_wr_reg == pend_dst) |=>
      (rf_we && !rf_wsel));

  // R11
  idle_decode_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !stall);

  // R6
  one_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !(ld_issue && (ex_wr_req || (pend_valid && !mem_ready))));

endmodule

bind ldsb_top ldsb_checker #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dec_valid    (dec_valid),
  .dec_is_load  (dec_is_load),
  .ex_wr_req    (ex_wr_req),
  .ex_wr_reg    (ex_wr_reg),
  .ld_issue     (ld_issue),
  .mem_ready    (mem_ready),
  .stall        (stall),
  .ex_hold      (ex_hold),
  .rf_we        (rf_we),
  .rf_waddr     (rf_waddr),
  .rf_wsel      (rf_wsel),
  .pend_valid   (pend_valid),
  .pend_dropped (pend_dropped),
  .pend_dst     (pend_dst)
);

// File: tb/tb_ldsb_top.sv
`timescale 1ns/1ps
module tb_ldsb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       dec_valid, dec_is_load;
  logic [7:0] dec_src;
  logic       ex_wr_req;
  logic [3:0] ex_wr_reg;
  logic       ld_issue;
  logic [3:0] ld_dst;
  logic       mem_ready;
  logic       stall, ex_hold, rf_we, rf_wsel;
  logic [3:0] rf_waddr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [4:0] exp_q[$];  // {sel, addr}

  always #10 clk = ~clk;

  ldsb_top dut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_is_load(dec_is_load),
    .dec_src(dec_src), .ex_wr_req(ex_wr_req), .ex_wr_reg(ex_wr_reg),
    .ld_issue(ld_issue), .ld_dst(ld_dst), .mem_ready(mem_ready),
    .stall(stall), .ex_hold(ex_hold), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wsel(rf_wsel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [3:0] addr, input logic sel);
    exp_q.push_back({sel, addr});
  endtask

  // Monitor: pops the scoreboard on every write seen at the port
  always @(negedge clk) begin
    if (!rst && rf_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7/R10 unexpected write", {rf_wsel, rf_waddr}, 0);
      end else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        chk({rf_wsel, rf_waddr} == e, "R2/R3/R4/R8/R9 write", {rf_wsel, rf_waddr}, e);
      end
    end
  end

  task automatic idle();
    dec_valid = 0; dec_is_load = 0; dec_src = 8'h00;
    ex_wr_req = 0; ex_wr_reg = 0; ld_issue = 0; ld_dst = 0; mem_ready = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic decode(input logic ld, input logic [3:0] a, input logic [3:0] b);
    dec_valid = 1; dec_is_load = ld; dec_src = {b, a}; #1;
  endtask

  initial begin
    rst = 1; idle();
    tick(); tick();
    rst = 0; #1;
    // R1 reset state
    chk(rf_we == 0 && stall == 0 && ex_hold == 0, "R1 reset outputs", {rf_we, stall, ex_hold}, 0);
    decode(1, 4'd0, 4'd0);
    chk(stall == 0, "R1 no pending after reset", stall, 0);
    idle();

    // R2 plain execute write
    ex_wr_req = 1; ex_wr_reg = 4'd3; expect_wr(4'd3, 1'b0);
    tick(); idle(); tick();

    // load to r5, variable latency
    ld_issue = 1; ld_dst = 4'd5; tick(); idle();
    decode(0, 4'd5, 4'd1); chk(stall == 1, "R5 src A match", stall, 1);
    decode(0, 4'd2, 4'd5); chk(stall == 1, "R5 src B match", stall, 1);
    decode(0, 4'd6, 4'd7); chk(stall == 0, "R4 independent decode", stall, 0);
    decode(1, 4'd6, 4'd7); chk(stall == 1, "R6 second load", stall, 1);
    dec_valid = 0; dec_src = 8'h55; #1;
    chk(stall == 0, "R11 bubble no stall", stall, 0);
    idle();
    ex_wr_req = 1; ex_wr_reg = 4'd8; expect_wr(4'd8, 1'b0);  // R4 out-of-order
    tick(); idle();
    for (int i = 0; i < 6; i++) tick();
    decode(0, 4'd5, 4'd5); chk(stall == 1, "R10 still pending", stall, 1);
    mem_ready = 1; #1;
    chk(stall == 1, "R5 stall in return cycle", stall, 1);
    expect_wr(4'd5, 1'b1);                                      // R3
    tick(); idle();
    decode(0, 4'd5, 4'd0); chk(stall == 0, "R5 released", stall, 0);
    idle();

    // R10 stray ready
    mem_ready = 1; tick(); idle(); tick();

    // R7 cancel
    ld_issue = 1; ld_dst = 4'd9; tick(); idle();
    ex_wr_req = 1; ex_wr_reg = 4'd9; #1;
    chk(ex_hold == 0, "R7 cancel no hold", ex_hold, 0);
    expect_wr(4'd9, 1'b0);
    tick(); idle();
    decode(0, 4'd9, 4'd9); chk(stall == 0, "R7 reader free", stall, 0);
    decode(1, 4'd0, 4'd0); chk(stall == 1, "R6 cancelled still pending", stall, 1);
    idle();
    mem_ready = 1; tick(); idle(); tick();
    decode(1, 4'd0, 4'd0); chk(stall == 0, "R7 pending cleared", stall, 0);
    idle();

    // R8 port conflict, different register
    ld_issue = 1; ld_dst = 4'd2; tick(); idle();
    mem_ready = 1; ex_wr_req = 1; ex_wr_reg = 4'd4; #1;
    chk(ex_hold == 1, "R8 hold asserted", ex_hold, 1);
    expect_wr(4'd2, 1'b1);
    tick();
    mem_ready = 0; #1;
    chk(ex_hold == 0, "R8 hold released", ex_hold, 0);
    expect_wr(4'd4, 1'b0);
    tick(); idle(); tick();

    // R9 same register on return
    ld_issue = 1; ld_dst = 4'd11; tick(); idle();
    mem_ready = 1; ex_wr_req = 1; ex_wr_reg = 4'd11; #1;
    chk(ex_hold == 0, "R9 no hold", ex_hold, 0);
    expect_wr(4'd11, 1'b0);
    tick(); idle(); tick(); tick();
    decode(0, 4'd11, 4'd0); chk(stall == 0, "R9 cleared", stall, 0);
    idle();

    // R1 reset while pending
    ld_issue = 1; ld_dst = 4'd1; tick(); idle();
    rst = 1; tick(); rst = 0; #1;
    decode(0, 4'd1, 4'd1);
    chk(stall == 0 && rf_we == 0, "R1 reset mid-load", {stall, rf_we}, 0);
    idle(); tick(); tick();

    chk(exp_q.size() == 0, "R3/R8 writes outstanding", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule